// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight edge-sensitive interrupt request lines and presents a single interrupt output to a processor. Line 0 always wins over higher-numbered lines. A line that has been acknowledged stays in service until software retires it with an end-of-interrupt command. While it is in service, it blocks any request of equal or lower priority from raising the output.

Software reaches the block over an 8-bit register bus with one address bit. Address 0 is the command port and address 1 is the data port. A start command opens a three-byte set-up sequence on the data port: vector base, cascade byte, mode byte. After that, data-port writes load the line mask.

The processor can take an interrupt in one of two ways:
- an acknowledge pulse, which returns a vector byte in the same cycle;
- an armed poll followed by a command-port read, which reports the winning line number.

Command-port reads return either the request register or the in-service register, as selected by the last select command.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask is 0xFF, no request is pending, no line is in service, the interrupt output is low, command-port reads return the request register, and data-port writes load the mask.
- R2: Writing 0x11 to address 0 clears the pending and in-service registers and selects request readback. The next three writes to address 1 are taken in order as vector base, cascade byte (driven on `cascadeCfg`) and mode byte (consumed without effect), and none of them changes the mask.
- R3: A request is latched only on a rising edge of its line. A line that is held high does not latch again after its request has been acknowledged.
- R4: Outside set-up, a write to address 1 loads the mask, and a read of address 1 returns it. A mask bit of 1 keeps that line from raising the interrupt and from being acknowledged.
- R5: `intOut` is high exactly when the lowest-numbered unmasked pending line has a lower number than every in-service line.
- R6: In a cycle with `intAck` high and an eligible winner, `busRData` equals vector base + line number. On the next edge the line leaves the pending register and enters the in-service register.
- R7: An acknowledge with no eligible winner returns vector base + 7 and leaves the in-service and pending registers unchanged (spurious line 7).
- R8: Writing 0x0C to address 0 arms a poll. The next read of address 0 returns 0x80 | line and acknowledges that line, or returns 0x07 if no line is eligible. Only that one read is affected.
- R9: Writing 0x0B to address 0 selects in-service readback and writing 0x0A selects request readback. The selection holds across any number of reads and other commands.
- R10: Writing 0x20 to address 0 clears the lowest-numbered set bit of the in-service register.
- R11: A write to address 0 of any value other than 0x11, 0x0C, 0x0B, 0x0A or 0x20 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 1 | Register select: 0 command port, 1 data port |
| busWr | input | 1 | One-cycle write strobe |
| busRd | input | 1 | One-cycle read strobe |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data, valid in the strobe cycle |
| irqReq | input | 8 | Interrupt request lines, bit 0 highest priority |
| intAck | input | 1 | One-cycle interrupt-acknowledge strobe |
| intOut | output | 1 | Interrupt request to the processor |
| cascadeCfg | output | 8 | Cascade byte stored during set-up |

## Verification
The assertions assume the following of the inputs:
- `intAck` is never high in the same cycle as a command-port read or write.
- Each bus strobe lasts exactly one cycle.
- No end-of-interrupt command arrives in the cycle of an acknowledge.

Under these assumptions, the in-service count changes by exactly one per grant or retirement. The stimulus keeps within them because every bus access and acknowledge is issued by its own task, which raises one strobe for one cycle and drops it before the next access begins. Request lines change only on falling clock edges and are pulsed or held deliberately, so every latched edge is planned.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  typedef enum logic [2:0] {
    RS_IRR,
    RS_ISR,
    RS_POLL,
    RS_VEC,
    RS_MASK
  } rdSel_e;

  typedef struct packed {
    logic   ackGo;
    logic   pollGo;
    logic   eoiGo;
    logic   maskLd;
    logic   baseLd;
    logic   cascLd;
    logic   initClr;
    rdSel_e rdSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/irqc_ctrl.sv
module irqc_ctrl
  import irqc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          busAddr,
  input  logic          busWr,
  input  logic          busRd,
  input  logic [DW-1:0] busWData,
  input  logic          intAck,
  output ctrlStrobe_t   strobe
);

  localparam logic [DW-1:0] CMD_INIT    = DW'(8'h11);
  localparam logic [DW-1:0] CMD_POLL    = DW'(8'h0C);
  localparam logic [DW-1:0] CMD_SEL_ISR = DW'(8'h0B);
  localparam logic [DW-1:0] CMD_SEL_IRR = DW'(8'h0A);
  localparam logic [DW-1:0] CMD_EOI     = DW'(8'h20);

  typedef enum logic [1:0] {IS_IDLE, IS_BASE, IS_CASC, IS_MODE} initState_e;

  initState_e initState;
  logic       pollArmed;
  logic       selIsr;

  logic cmdWr, dataWr, cmdRd;
  assign cmdWr  = busWr && !busAddr;
  assign dataWr = busWr && busAddr;
  assign cmdRd  = busRd && !busAddr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      initState <= IS_IDLE;
      pollArmed <= 1'b0;
      selIsr    <= 1'b0;
    end else begin
      if (cmdRd && pollArmed) pollArmed <= 1'b0;
      if (cmdWr) begin
        case (busWData)
          CMD_INIT: begin
            initState <= IS_BASE;
            pollArmed <= 1'b0;
            selIsr    <= 1'b0;
          end
          CMD_POLL:    pollArmed <= 1'b1;
          CMD_SEL_ISR: selIsr    <= 1'b1;
          CMD_SEL_IRR: selIsr    <= 1'b0;
          default: ;
        endcase
      end
      if (dataWr) begin
        case (initState)
          IS_BASE: initState <= IS_CASC;
          IS_CASC: initState <= IS_MODE;
          IS_MODE: initState <= IS_IDLE;
          default: initState <= IS_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.initClr = cmdWr && (busWData == CMD_INIT);
    strobe.eoiGo   = cmdWr && (busWData == CMD_EOI);
    strobe.maskLd  = dataWr && (initState == IS_IDLE);
    strobe.baseLd  = dataWr && (initState == IS_BASE);
    strobe.cascLd  = dataWr && (initState == IS_CASC);
    strobe.pollGo  = cmdRd && pollArmed;
    strobe.ackGo   = intAck;
    if (intAck)          strobe.rdSel = RS_VEC;
    else if (busAddr)    strobe.rdSel = RS_MASK;
    else if (pollArmed)  strobe.rdSel = RS_POLL;
    else if (selIsr)     strobe.rdSel = RS_ISR;
    else                 strobe.rdSel = RS_IRR;
  end

  AST_POLL_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRd && pollArmed && !cmdWr) |=> !pollArmed); // R8

  AST_INIT_ORDER: assert property (@(posedge clk) disable iff (!rstN)
    (initState == IS_BASE && dataWr && !cmdWr) |=> (initState == IS_CASC)); // R2

  AST_SELECT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdWr) |=> $stable(selIsr)); // R9

endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DW        = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobe_t          strobe,
  input  logic [DW-1:0]        wData,
  input  logic [NUM_LINES-1:0] irqReq,
  output logic [DW-1:0]        rData,
  output logic                 intOut,
  output logic [DW-1:0]        cascadeCfg
);

  localparam int LW = $clog2(NUM_LINES);
  localparam logic [LW-1:0] LAST_LINE = LW'(NUM_LINES - 1);

  logic [NUM_LINES-1:0] pending, inService, maskReg, reqPrev, rise;
  logic [DW-1:0]        vecBase, cascReg;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : gEdge
      assign rise[g] = irqReq[g] & ~reqPrev[g];
    end
  endgenerate

  logic [NUM_LINES-1:0] eligible;
  logic                 reqFound, isrFound;
  logic [LW-1:0]        reqLine, isrLine;

  assign eligible = pending & ~maskReg;

  always_comb begin
    reqFound = 1'b0;
    reqLine  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (eligible[i]) begin
        reqFound = 1'b1;
        reqLine  = LW'(i);
      end
    end
  end

  always_comb begin
    isrFound = 1'b0;
    isrLine  = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (inService[i]) begin
        isrFound = 1'b1;
        isrLine  = LW'(i);
      end
    end
  end

  logic reqAbove, grantGo;
  logic [NUM_LINES-1:0] grantVec, eoiVec;

  assign reqAbove = reqFound && (!isrFound || (reqLine < isrLine));
  assign intOut   = reqAbove;
  assign grantGo  = (strobe.ackGo || strobe.pollGo) && reqAbove;
  assign grantVec = grantGo ? (NUM_LINES'(1) << reqLine) : '0;
  assign eoiVec   = (strobe.eoiGo && isrFound) ? (NUM_LINES'(1) << isrLine) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending   <= '0;
      inService <= '0;
      maskReg   <= '1;
      reqPrev   <= '0;
      vecBase   <= '0;
      cascReg   <= '0;
    end else begin
      reqPrev <= irqReq;
      if (strobe.initClr) begin
        pending   <= '0;
        inService <= '0;
      end else begin
        pending   <= (pending & ~grantVec) | rise;
        inService <= (inService & ~eoiVec) | grantVec;
      end
      if (strobe.maskLd) maskReg <= wData[NUM_LINES-1:0];
      if (strobe.baseLd) vecBase <= wData;
      if (strobe.cascLd) cascReg <= wData;
    end
  end

  assign cascadeCfg = cascReg;

  logic [DW-1:0] vecByte, pollByte;
  assign vecByte  = vecBase + DW'(reqAbove ? reqLine : LAST_LINE);
  assign pollByte = reqAbove ? {1'b1, {(DW-1-LW){1'b0}}, reqLine}
                             : {1'b0, {(DW-1-LW){1'b0}}, LAST_LINE};

  always_comb begin
    case (strobe.rdSel)
      RS_VEC:  rData = vecByte;
      RS_POLL: rData = pollByte;
      RS_MASK: rData = DW'(maskReg);
      RS_ISR:  rData = DW'(inService);
      default: rData = DW'(pending);
    endcase
  end

  AST_INT_NEEDS_UNMASKED: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> ((pending & ~maskReg) != '0)); // R5

  AST_GRANT_ADDS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (grantGo && !strobe.eoiGo && !strobe.initClr) |=>
      ($countones(inService) == $past($countones(inService)) + 1)); // R6

  AST_SPURIOUS_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.ackGo && !reqAbove && !strobe.eoiGo && !strobe.initClr) |=>
      $stable(inService)); // R7

  AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.eoiGo && (inService != '0) && !grantGo && !strobe.initClr) |=>
      ($countones(inService) == $past($countones(inService)) - 1)); // R10

  AST_MASK_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.maskLd) |=> $stable(maskReg)); // R4

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int DW        = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 busAddr,
  input  logic                 busWr,
  input  logic                 busRd,
  input  logic [DW-1:0]        busWData,
  output logic [DW-1:0]        busRData,
  input  logic [NUM_LINES-1:0] irqReq,
  input  logic                 intAck,
  output logic                 intOut,
  output logic [DW-1:0]        cascadeCfg
);

  ctrlStrobe_t strobe;

  irqc_ctrl #(.DW(DW)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .busWData (busWData),
    .intAck   (intAck),
    .strobe   (strobe)
  );

  irqc_datapath #(.NUM_LINES(NUM_LINES), .DW(DW)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wData      (busWData),
    .irqReq     (irqReq),
    .rData      (busRData),
    .intOut     (intOut),
    .cascadeCfg (cascadeCfg)
  );

endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busAddr = 1'b0, busWr = 1'b0, busRd = 1'b0, intAck = 1'b0;
  logic [7:0] busWData = '0, irqReq = '0;
  logic [7:0] busRData, cascadeCfg;
  logic       intOut;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] expQ[$];
  string      tagQ[$];

  always #5 clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWData(busWData), .busRData(busRData), .irqReq(irqReq), .intAck(intAck),
    .intOut(intOut), .cascadeCfg(cascadeCfg)
  );

  function automatic void compare(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
    end
  endfunction

  // monitor: pops one expectation for every read or acknowledge cycle
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (busRd || intAck) begin
        if (expQ.size() == 0) compare(busRData, 8'hxx, "unexpected read");
        else compare(busRData, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); busAddr = a; busWData = d; busWr = 1'b1;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rd(input logic a, input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); busAddr = a; busRd = 1'b1;
    @(negedge clk); busRd = 1'b0;
  endtask

  task automatic ack(input logic [7:0] exp, input string tag);
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk); intAck = 1'b1;
    @(negedge clk); intAck = 1'b0;
  endtask

  task automatic pulse(input int line);
    @(negedge clk); irqReq[line] = 1'b1;
    @(negedge clk); irqReq[line] = 1'b0;
  endtask

  task automatic chkInt(input logic exp, input string tag);
    @(negedge clk); #3;
    compare({7'b0, intOut}, {7'b0, exp}, tag);
  endtask

  task automatic chkCasc(input logic [7:0] exp, input string tag);
    @(negedge clk); #3;
    compare(cascadeCfg, exp, tag);
  endtask

  task automatic finishRun;
    if (expQ.size() != 0) compare(8'(expQ.size()), 8'h00, "leftover expectations");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      compare(8'h01, 8'h00, "watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chkInt(1'b0, "R1 intOut after reset");
    rd(1'b1, 8'hFF, "R1 mask after reset");
    rd(1'b0, 8'h00, "R1 request readback after reset");
    // R2 set-up with base 0x08
    wr(1'b0, 8'h11); wr(1'b1, 8'h08); wr(1'b1, 8'h04); wr(1'b1, 8'h01);
    chkCasc(8'h04, "R2 cascade byte");
    rd(1'b1, 8'hFF, "R2 set-up writes leave mask");
    wr(1'b1, 8'h00);
    rd(1'b1, 8'h00, "R4 mask load");
    // R5/R6 priority and vectors
    pulse(3); pulse(5);
    chkInt(1'b1, "R5 intOut with pending");
    rd(1'b0, 8'h28, "R9 default request readback");
    ack(8'h0B, "R6 vector line 3");
    chkInt(1'b0, "R5 line 5 below in-service 3");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h08, "R9 in-service readback");
    pulse(1);
    chkInt(1'b1, "R5 line 1 above in-service 3");
    ack(8'h09, "R6 vector line 1");
    rd(1'b0, 8'h0A, "R9 selection persists");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h08, "R10 EOI clears line 1");
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h00, "R10 EOI clears line 3");
    chkInt(1'b1, "R5 line 5 now eligible");
    ack(8'h0D, "R6 vector line 5");
    wr(1'b0, 8'h20);
    // R11 ignored command, R9 reselect
    pulse(6);
    wr(1'b0, 8'h55);
    rd(1'b0, 8'h00, "R11 unknown command keeps in-service select");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h40, "R9 request select");
    ack(8'h0E, "R6 vector line 6");
    wr(1'b0, 8'h20);
    // R4 mask blocks, R7 spurious
    wr(1'b1, 8'hFB);
    pulse(4);
    chkInt(1'b0, "R4 masked line 4 holds intOut low");
    rd(1'b0, 8'h10, "R4 masked line still pending");
    ack(8'h0F, "R7 spurious vector");
    rd(1'b0, 8'h10, "R7 pending unchanged");
    wr(1'b0, 8'h0B);
    rd(1'b0, 8'h00, "R7 in-service unchanged");
    pulse(2);
    chkInt(1'b1, "R4 unmasked line 2 raises intOut");
    ack(8'h0A, "R6 vector line 2");
    wr(1'b0, 8'h20);
    // R8 poll
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h84, "R8 poll finds line 4");
    rd(1'b0, 8'h10, "R8 poll one-shot, line 4 in service");
    wr(1'b0, 8'h20);
    wr(1'b0, 8'h0C);
    rd(1'b0, 8'h07, "R8 poll finds nothing");
    // R3 level held
    @(negedge clk); irqReq[6] = 1'b1;
    chkInt(1'b1, "R3 rising edge latches");
    ack(8'h0E, "R3 vector line 6");
    wr(1'b0, 8'h20);
    chkInt(1'b0, "R3 held level does not relatch");
    wr(1'b0, 8'h0A);
    rd(1'b0, 8'h00, "R3 no pending after held level");
    @(negedge clk); irqReq[6] = 1'b0;
    // R2 re-init clears state, new base 0x00
    pulse(5);
    wr(1'b0, 8'h11); wr(1'b1, 8'h00); wr(1'b1, 8'h02); wr(1'b1, 8'h01);
    chkCasc(8'h02, "R2 new cascade byte");
    chkInt(1'b0, "R2 set-up clears pending");
    rd(1'b0, 8'h00, "R2 request register cleared");
    rd(1'b1, 8'h00, "R2 mask kept through set-up");
    pulse(0);
    ack(8'h00, "R6 vector line 0 base 0x00");
    repeat (3) @(negedge clk);
    done = 1;
    finishRun();
  end

endmodule